// File: doc/BRIEF.md
# PWM Compare Timer

A 16-bit up-counting timer that generates a pulse-width-modulated waveform from two compare registers. The counter advances on count ticks taken either from a divided system clock (divide by 2, 4 or 8) or from rising edges of an external timer clock. The period compare register sets the period. When the counter equals it on a tick, the counter reloads to 16'hFFFC instead of 0. A period compare value of N therefore gives a period of N+5 ticks. The edge compare register sets where the output changes level inside that period. At the edge match the output takes `edge_lvl`. At the period match it takes `period_lvl`.

Software loads each compare register as two bytes. Writing the high byte takes that channel out of service until its low byte arrives, so a half-written value never produces a match. In PWM mode the ordinary compare flags stay clear, and the period match raises capture flag A instead. Capture pin A is ignored in that mode. Capture pin B keeps working in every mode. Outside PWM mode the counter runs freely and wraps. Matches then only set the compare flags, and both capture pins load their registers. PWM mode takes priority when the one-pulse request is also set.

Each compare channel holds a two-state write machine. `CMP_LIVE` moves to `CMP_HELD` on a high-byte write with no low-byte write in the same cycle. `CMP_HELD` moves back to `CMP_LIVE` on a low-byte write. The timer mode is decoded each cycle into `MODE_PWM`, `MODE_ONEPULSE` or `MODE_FREE`. `MODE_ONEPULSE` behaves as `MODE_FREE` in this block.

Top module: `pwm_timer`

## Requirements
- R1: After reset the count is 16'hFFFC, both compare registers are 0 and live, `pwm_out` is 0, all flags and both capture values are 0, and `irq` is 0.
- R2: The count increments by one on each tick and wraps from 16'hFFFF to 0. In PWM mode, a tick on which the count equals the live period compare value loads 16'hFFFC instead, giving a period of (value+5) ticks.
- R3: In PWM mode an edge match on a tick sets `pwm_out` to `edge_lvl` and a period match sets it to `period_lvl`. When both match on the same tick, `period_lvl` wins. Outside PWM mode `pwm_out` holds its value.
- R4: `clk_sel` 0, 1 and 2 give a tick on every 2nd, 4th or 8th clock, the first on clock 2, 4 or 8 after reset. `clk_sel` 3 gives one tick per rising edge of `ext_clk`, seen through a two-flop synchroniser.
- R5: When `edge_lvl` equals `period_lvl` and `pwm_out` already has that level, `pwm_out` stays constant.
- R6: `cmp_sel` 0 selects the edge register and 1 the period register. `wr_hi` writes `wr_data` to bits 15:8 and takes the channel out of service. `wr_lo` writes bits 7:0 and puts it back in service. A channel out of service produces no match.
- R7: Flag bit 2 (edge compare) and bit 3 (period compare) are set by matches only outside PWM mode, and are never set in PWM mode.
- R8: Flag bit 0 is set by a period match in PWM mode. Outside PWM mode it is set, and `cap_a_val` loads the count, on the selected edge of `cap_a_pin`. In PWM mode `cap_a_pin` has no effect.
- R9: A 1 in bit i of `clr_flags` clears flag i, and a set in the same cycle wins. `irq` = !`irq_mask` & ((`cap_ie` & (flag0|flag1)) | (`cmp_ie` & (flag2|flag3))).
- R10: In any mode, the selected edge of `cap_b_pin` sets flag bit 1 and loads `cap_b_val` with the count held at that clock. The edge is rising when `cap_rise`=1 and falling when it is 0, after a two-flop synchroniser.
- R11: With both `pwm_en` and `opm_en` set, the block behaves exactly as in PWM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_en | input | 1 | PWM mode request |
| opm_en | input | 1 | One-pulse mode request (lower priority) |
| clk_sel | input | 2 | Tick source: /2, /4, /8, external |
| ext_clk | input | 1 | External timer clock |
| cmp_sel | input | 1 | Compare register select: 0 edge, 1 period |
| wr_hi | input | 1 | Write high byte of selected compare |
| wr_lo | input | 1 | Write low byte of selected compare |
| wr_data | input | 8 | Byte being written |
| edge_lvl | input | 1 | Output level applied at the edge match |
| period_lvl | input | 1 | Output level applied at the period match |
| cap_a_pin | input | 1 | Capture input A |
| cap_b_pin | input | 1 | Capture input B |
| cap_rise | input | 1 | Capture edge polarity: 1 rising, 0 falling |
| clr_flags | input | 4 | Write-one-to-clear pulses for the flags |
| cap_ie | input | 1 | Capture flag interrupt enable |
| cmp_ie | input | 1 | Compare flag interrupt enable |
| irq_mask | input | 1 | Global interrupt mask |
| pwm_out | output | 1 | PWM waveform |
| count | output | 16 | Counter value |
| cap_a_val | output | 16 | Capture register A |
| cap_b_val | output | 16 | Capture register B |
| flags | output | 4 | {cmp period, cmp edge, cap B, cap A/period} |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the period between reloads. A design that reloaded to zero, or compared one tick late, would show a period other than (N+5)·divider. It sets both compares equal, which catches an output that lets the edge level override the period level. It leaves a channel half-written while the counter sweeps past the old compare value: a design that ignores the write inhibit would reload early, and one that never releases the inhibit would never reload again. It toggles capture pin A in PWM mode, changes tick divisors and the external clock while running, and raises both mode requests. A leaking capture, a wrong divisor or a wrong mode priority then shows up as a difference in flags, capture values or count against the cycle model.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    typedef enum logic {
        CMP_LIVE,
        CMP_HELD
    } cmp_state_t;

    typedef enum logic [1:0] {
        MODE_FREE,
        MODE_ONEPULSE,
        MODE_PWM
    } tmr_mode_t;

    localparam int FLG_CAP_A = 0;
    localparam int FLG_CAP_B = 1;
    localparam int FLG_CMP_E = 2;
    localparam int FLG_CMP_P = 3;
    localparam int FLG_W     = 4;

    // PWM request outranks the one-pulse request
    function automatic tmr_mode_t pick_mode(input logic pwm, input logic opm);
        if (pwm)      return MODE_PWM;
        else if (opm) return MODE_ONEPULSE;
        else          return MODE_FREE;
    endfunction

endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
    parameter int DIV_W = 3,
    parameter int SYNC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel,
    input  logic       ext_clk,
    output logic       tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic [SYNC:0]    ext_sh;
    logic             ext_rise;
    logic             int_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            ext_sh <= '0;
        end else begin
            div_q  <= div_q + 1'b1;
            ext_sh <= {ext_sh[SYNC-1:0], ext_clk};
        end
    end

    always_comb begin
        case (clk_sel)
            2'd0:    mask = DIV_W'(1);
            2'd1:    mask = DIV_W'(3);
            2'd2:    mask = DIV_W'(7);
            default: mask = '0;
        endcase
    end

    assign int_tick = ((div_q & mask) == mask);
    assign ext_rise = ext_sh[SYNC-1] & ~ext_sh[SYNC];
    assign tick     = (clk_sel == 2'd3) ? ext_rise : int_tick;

    // R4: internal divided ticks are never back to back
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clk_sel != 2'd3) |=> (clk_sel == 2'd3 || !tick));

endmodule

// File: rtl/pwmt_cmp_reg.sv
module pwmt_cmp_reg
    import pwmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [7:0]   wr_data,
    output logic [W-1:0] value,
    output logic         live
);
    localparam int HI_W = W - 8;

    cmp_state_t st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CMP_LIVE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CMP_LIVE: if (wr_hi && !wr_lo) st_d = CMP_HELD;
            CMP_HELD: if (wr_lo)           st_d = CMP_LIVE;
            default:                       st_d = CMP_LIVE;
        endcase
    end

    // outputs
    always_comb begin
        live = (st_q == CMP_LIVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            if (wr_hi) value[W-1:8] <= HI_W'(wr_data);
            if (wr_lo) value[7:0]   <= wr_data;
        end
    end

    // R6: a lone high-byte write takes the channel out of service
    assert_hi_inhibits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> !live);
    // R6: a low-byte write puts it back in service
    assert_lo_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> live);

endmodule

// File: rtl/pwmt_capture.sv
module pwmt_capture #(
    parameter int W    = 16,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic         rise_sel,
    input  logic         enable,
    input  logic [W-1:0] count,
    output logic         hit,
    output logic [W-1:0] value
);
    logic [SYNC:0] sh;
    logic          rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC-1:0], pin};
    end

    assign rise = sh[SYNC-1] & ~sh[SYNC];
    assign fall = ~sh[SYNC-1] & sh[SYNC];
    assign hit  = enable & (rise_sel ? rise : fall);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (hit) value <= count;
    end

    // R10: a capture loads the count seen at that clock
    assert_capture_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (value == $past(count)));

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 3,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_en,
    input  logic             opm_en,
    input  logic [1:0]       clk_sel,
    input  logic             ext_clk,
    input  logic             cmp_sel,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [7:0]       wr_data,
    input  logic             edge_lvl,
    input  logic             period_lvl,
    input  logic             cap_a_pin,
    input  logic             cap_b_pin,
    input  logic             cap_rise,
    input  logic [FLG_W-1:0] clr_flags,
    input  logic             cap_ie,
    input  logic             cmp_ie,
    input  logic             irq_mask,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_a_val,
    output logic [CNT_W-1:0] cap_b_val,
    output logic [FLG_W-1:0] flags,
    output logic             irq
);
    localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}} - CNT_W'(3);

    tmr_mode_t        mode;
    logic             in_pwm;
    logic             tick;
    logic [CNT_W-1:0] cmp_e_v, cmp_p_v;
    logic             live_e, live_p;
    logic             hit_e, hit_p;
    logic             cap_a_hit, cap_b_hit;
    logic [CNT_W-1:0] cnt_q;
    logic             out_q;
    logic [FLG_W-1:0] flg_q, flg_set;

    assign mode   = pick_mode(pwm_en, opm_en);
    assign in_pwm = (mode == MODE_PWM);

    pwmt_prescale #(.DIV_W(DIV_W), .SYNC(SYNC)) u_pre (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk), .tick(tick)
    );

    pwmt_cmp_reg #(.W(CNT_W)) u_cmp_e (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_hi & ~cmp_sel), .wr_lo(wr_lo & ~cmp_sel), .wr_data(wr_data),
        .value(cmp_e_v), .live(live_e)
    );

    pwmt_cmp_reg #(.W(CNT_W)) u_cmp_p (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_hi & cmp_sel), .wr_lo(wr_lo & cmp_sel), .wr_data(wr_data),
        .value(cmp_p_v), .live(live_p)
    );

    pwmt_capture #(.W(CNT_W), .SYNC(SYNC)) u_cap_a (
        .clk(clk), .rst_n(rst_n), .pin(cap_a_pin), .rise_sel(cap_rise),
        .enable(~in_pwm), .count(cnt_q), .hit(cap_a_hit), .value(cap_a_val)
    );

    pwmt_capture #(.W(CNT_W), .SYNC(SYNC)) u_cap_b (
        .clk(clk), .rst_n(rst_n), .pin(cap_b_pin), .rise_sel(cap_rise),
        .enable(1'b1), .count(cnt_q), .hit(cap_b_hit), .value(cap_b_val)
    );

    assign hit_e = tick & live_e & (cnt_q == cmp_e_v);
    assign hit_p = tick & live_p & (cnt_q == cmp_p_v);

    // counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= RELOAD;
        else if (tick && in_pwm && hit_p) cnt_q <= RELOAD;
        else if (tick)             cnt_q <= cnt_q + 1'b1;
    end

    // waveform: period level outranks edge level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 out_q <= 1'b0;
        else if (in_pwm && hit_p)   out_q <= period_lvl;
        else if (in_pwm && hit_e)   out_q <= edge_lvl;
    end

    always_comb begin
        flg_set            = '0;
        flg_set[FLG_CAP_A] = (in_pwm & hit_p) | cap_a_hit;
        flg_set[FLG_CAP_B] = cap_b_hit;
        flg_set[FLG_CMP_E] = ~in_pwm & hit_e;
        flg_set[FLG_CMP_P] = ~in_pwm & hit_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= (flg_q & ~clr_flags) | flg_set;
    end

    assign pwm_out = out_q;
    assign count   = cnt_q;
    assign flags   = flg_q;
    assign irq     = ~irq_mask & ((cap_ie & (flg_q[FLG_CAP_A] | flg_q[FLG_CAP_B])) |
                                  (cmp_ie & (flg_q[FLG_CMP_E] | flg_q[FLG_CMP_P])));

    // R2: period match in PWM mode reloads the counter
    assert_period_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pwm && hit_p) |=> (cnt_q == RELOAD));
    // R3: period match drives the period level
    assert_period_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pwm && hit_p) |=> (out_q == $past(period_lvl)));
    // R5: equal levels hold the waveform
    assert_flat_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pwm && edge_lvl == period_lvl && out_q == edge_lvl) |=> $stable(out_q));
    // R7: compare flags never rise in PWM mode
    assert_no_cmp_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pwm && flg_q[FLG_CMP_E] == 1'b0 && flg_q[FLG_CMP_P] == 1'b0)
        |=> (flg_q[FLG_CMP_E] == 1'b0 && flg_q[FLG_CMP_P] == 1'b0));
    // R8: period match raises capture flag A
    assert_period_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pwm && hit_p) |=> flg_q[FLG_CAP_A]);
    // R11: both mode requests still reload on period match
    assert_mode_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && opm_en && hit_p) |=> (cnt_q == RELOAD));

endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pwm_en, opm_en, ext_clk, cmp_sel, wr_hi, wr_lo;
    logic [1:0]  clk_sel;
    logic [7:0]  wr_data;
    logic        edge_lvl, period_lvl, cap_a_pin, cap_b_pin, cap_rise;
    logic [3:0]  clr_flags;
    logic        cap_ie, cmp_ie, irq_mask;
    logic        pwm_out, irq;
    logic [15:0] count, cap_a_val, cap_b_val;
    logic [3:0]  flags;

    always #4 clk = ~clk;

    pwm_timer dut (
        .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .opm_en(opm_en), .clk_sel(clk_sel),
        .ext_clk(ext_clk), .cmp_sel(cmp_sel), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .edge_lvl(edge_lvl), .period_lvl(period_lvl), .cap_a_pin(cap_a_pin),
        .cap_b_pin(cap_b_pin), .cap_rise(cap_rise), .clr_flags(clr_flags), .cap_ie(cap_ie),
        .cmp_ie(cmp_ie), .irq_mask(irq_mask), .pwm_out(pwm_out), .count(count),
        .cap_a_val(cap_a_val), .cap_b_val(cap_b_val), .flags(flags), .irq(irq)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R1";
    bit    cmp_on = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, phase, act, exp);
        end
    endtask

    // behavioural reference model
    logic [15:0] m_cnt, m_ce, m_cp, m_ca, m_cb;
    logic        m_le, m_lp, m_out;
    logic [3:0]  m_flg;
    int          m_pc;
    logic [2:0]  m_ext, m_sa, m_sb;

    always @(posedge clk) begin : model
        int   msk;
        bit   tk, pw, me, mp, ea, eb;
        if (!rst_n) begin
            m_cnt = 16'hFFFC; m_ce = 0; m_cp = 0; m_ca = 0; m_cb = 0;
            m_le = 1; m_lp = 1; m_out = 0; m_flg = 0; m_pc = 0;
            m_ext = 0; m_sa = 0; m_sb = 0;
        end else begin
            msk = (clk_sel == 0) ? 1 : (clk_sel == 1) ? 3 : 7;
            tk  = (clk_sel == 3) ? (m_ext[1] && !m_ext[2]) : ((m_pc & msk) == msk);
            pw  = pwm_en;
            me  = tk && m_le && (m_cnt == m_ce);
            mp  = tk && m_lp && (m_cnt == m_cp);
            ea  = !pw && (cap_rise ? (m_sa[1] && !m_sa[2]) : (!m_sa[1] && m_sa[2]));
            eb  = cap_rise ? (m_sb[1] && !m_sb[2]) : (!m_sb[1] && m_sb[2]);
            if (ea) m_ca = m_cnt;
            if (eb) m_cb = m_cnt;
            m_flg = (m_flg & ~clr_flags) | {!pw && mp, !pw && me, eb, (pw && mp) || ea};
            if (pw && mp)      m_out = period_lvl;
            else if (pw && me) m_out = edge_lvl;
            if (tk) m_cnt = (pw && mp) ? 16'hFFFC : m_cnt + 16'd1;
            if (wr_hi && !cmp_sel) begin m_ce[15:8] = wr_data; m_le = 0; end
            if (wr_hi &&  cmp_sel) begin m_cp[15:8] = wr_data; m_lp = 0; end
            if (wr_lo && !cmp_sel) begin m_ce[7:0] = wr_data; m_le = 1; end
            if (wr_lo &&  cmp_sel) begin m_cp[7:0] = wr_data; m_lp = 1; end
            m_pc  = (m_pc + 1) % 8;
            m_ext = {m_ext[1:0], ext_clk};
            m_sa  = {m_sa[1:0], cap_a_pin};
            m_sb  = {m_sb[1:0], cap_b_pin};
        end
    end

    // per-cycle comparison and period monitor
    bit          per_on = 0;
    int          per_exp = 0;
    int          cyc = 0;
    int          last_rl = -1;
    logic [15:0] prev_cnt = 0;

    always @(negedge clk) begin
        #1;
        cyc++;
        if (cmp_on && rst_n) begin
            chk("R2 count", count, m_cnt);
            chk("R3 pwm_out", pwm_out, m_out);
            chk("R7 cmp flags", flags[3:2], m_flg[3:2]);
            chk("R8 cap A flag", flags[0], m_flg[0]);
            chk("R10 cap B flag", flags[1], m_flg[1]);
            chk("R8 cap A value", cap_a_val, m_ca);
            chk("R10 cap B value", cap_b_val, m_cb);
            chk("R9 irq", irq, !irq_mask && ((cap_ie && (m_flg[0] || m_flg[1])) ||
                                             (cmp_ie && (m_flg[2] || m_flg[3]))));
            if (per_on && count == 16'hFFFC && prev_cnt != 16'hFFFC) begin
                if (last_rl >= 0) chk("R2 period", cyc - last_rl, per_exp);
                last_rl = cyc;
            end
            prev_cnt = count;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk); cmp_sel = sel; wr_hi = 1; wr_data = hi;
        @(negedge clk); wr_hi = 0; wr_lo = 1; wr_data = lo;
        @(negedge clk); wr_lo = 0;
    endtask

    task automatic clr_all();
        @(negedge clk); clr_flags = 4'hF;
        @(negedge clk); clr_flags = 4'h0;
    endtask

    task automatic wiggle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i % 7 == 0)  cap_a_pin = ~cap_a_pin;
            if (i % 5 == 0)  cap_b_pin = ~cap_b_pin;
            clr_flags = (i % 40 == 39) ? 4'hF : 4'h0;
        end
        clr_flags = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        rst_n = 0; pwm_en = 0; opm_en = 0; clk_sel = 0; ext_clk = 0; cmp_sel = 0;
        wr_hi = 0; wr_lo = 0; wr_data = 0; edge_lvl = 0; period_lvl = 0;
        cap_a_pin = 0; cap_b_pin = 0; cap_rise = 1; clr_flags = 0;
        cap_ie = 0; cmp_ie = 0; irq_mask = 0;
        do_reset();
        #1;
        chk("R1 count", count, 16'hFFFC);
        chk("R1 pwm_out", pwm_out, 0);
        chk("R1 flags", flags, 0);
        chk("R1 irq", irq, 0);
        chk("R1 captures", {cap_a_val, cap_b_val}, 0);
        cmp_on = 1;

        phase = "R2 R3 divide by 2";
        pwm_en = 1; edge_lvl = 1; period_lvl = 0; cap_ie = 1;
        wr(0, 8'h00, 8'd10);
        wr(1, 8'h00, 8'd20);
        per_exp = 50; per_on = 1;
        run(300);
        per_on = 0; last_rl = -1;
        clr_all();

        phase = "R4 divide by 4";   clk_sel = 1; run(300);
        phase = "R4 divide by 8";   clk_sel = 2; run(500);
        clk_sel = 0;

        phase = "R3 equal compares"; wr(0, 8'h00, 8'd20); run(200);
        wr(0, 8'h00, 8'd10);

        phase = "R5 equal levels"; period_lvl = 1; run(150); period_lvl = 0;

        phase = "R11 both modes"; opm_en = 1; run(150); opm_en = 0;

        phase = "R6 half write";
        @(negedge clk); cmp_sel = 1; wr_hi = 1; wr_data = 8'h00;
        @(negedge clk); wr_hi = 0;
        run(120);
        wr_lo = 1; wr_data = 8'hC0;
        @(negedge clk); wr_lo = 0;
        run(600);
        do_reset();
        wr(0, 8'h00, 8'd10);
        wr(1, 8'h00, 8'd20);

        phase = "R8 R10 PWM captures";
        wiggle(200);
        cap_rise = 0; wiggle(150); cap_rise = 1;

        phase = "R7 R8 free running";
        pwm_en = 0; cmp_ie = 1;
        wiggle(200);
        phase = "R9 masking";
        irq_mask = 1; run(20); irq_mask = 0; cap_ie = 0; run(20); clr_all(); run(10);

        phase = "R4 external clock";
        pwm_en = 1; clk_sel = 3;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i % 3 == 0) ext_clk = ~ext_clk;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog [%s] actual=timeout expected=completion", phase);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule